// File: doc/BRIEF.md
# Debug Port JTAG Scan Target

This block is the scan-side front end of a debug port. A four-wire test access port (clock, mode select, serial in, serial out, plus an asynchronous reset) steps a standard 16-state controller. The controller selects between a 4-bit instruction register and five data registers. Any code outside the defined instruction set selects the one-bit bypass path, so no boundary-scan instructions are available.

Two 35-bit access scans move transactions into the block. One scan reaches the debug port's own registers: control/status, bank select and a read buffer. The other issues requests to an external access-port register bank over a single request/acknowledge pair. Each of these scans returns a 3-bit acknowledge and the result of the previous read. Read results are posted: a read request returns its data in the following access scan, or through the read buffer. A separate 35-bit scan reaches the abort register. This register can cancel a stuck access-port request. A fixed identification scan reports the port's version, part number and manufacturer code.

Top module: `jtdp_top`

## Requirements
- R1: An asynchronous reset, or reaching Test-Logic-Reset through the TAP, loads the identification instruction (1110). A data scan straight after reset therefore shifts out 0x3BA00477, LSB first.
- R2: During Capture-IR the instruction shift stage loads 0001, and an IR scan shifts that value out LSB first. TDI is sampled on the rising edge of TCK, and TDO changes on the falling edge.
- R3: The identification value has version 0x3 in bits 31:28, part number 0xBA00 in bits 27:12, manufacturer code 0x23B in bits 11:1, and bit 0 set to 1.
- R4: Instruction 1111 and every code other than 1110, 1010, 1011 and 1000 select a 1-bit bypass register. That register captures 0, so the scan output is the input delayed by one bit.
- R5: Instruction 1010 reaches the debug port. In the 35-bit scan, bit 0 is the read flag (1 = read), bits 2:1 are the address (01 control/status, 10 select, 11 read buffer), and bits 34:3 are the data. A write stores the data. A read posts the register value, and the next access scan returns it in bits 34:3 with acknowledge 010 in bits 2:0.
- R6: Address 00 is reserved. A write to it has no effect, and a read of it posts zero.
- R7: A read of address 11 returns the last posted value and leaves it unchanged. A write to address 11 has no effect.
- R8: Instruction 1011 launches an access-port request at Update-DR. The request carries the scanned address, a write flag equal to the inverted read flag, and the data. Address, flag and data stay stable until the acknowledge arrives. Read data returned with the acknowledge is posted to the next access scan.
- R9: If an access-port request is still outstanding when an access scan reaches Capture-DR, that scan returns acknowledge 001 with zero data, and its Update-DR is ignored. The outstanding request stays asserted until it is acknowledged or aborted.
- R10: Instruction 1000 selects the abort scan. If data bit 0 (scan bit 3) is 1 at Update-DR, the block raises a one-TCK-cycle abort pulse and drops any outstanding request. If that bit is 0, nothing happens.
- R11: An access scan only ever captures acknowledge 001 or 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial data in, LSB first |
| tdo_o | output | 1 | Serial data out, updated on the falling TCK edge |
| ap_req_o | output | 1 | Access-port request pending |
| ap_wr_o | output | 1 | Request is a write |
| ap_addr_o | output | 2 | Access-port register address |
| ap_wdata_o | output | DATA_W | Write data |
| ap_ack_i | input | 1 | Request completed (one cycle) |
| ap_rdata_i | input | DATA_W | Read data, valid with ap_ack_i |
| abort_o | output | 1 | One-cycle abort pulse |

## Verification
A TAP controller that goes astray shows up in the next scan: the identification value, the 0001 IR capture or the bypass delay comes out shifted, or the bits are wrong. A corrupted posted-read buffer or debug register shows on the very next access scan, because every such scan shifts the buffer out. A pending flag that clears early appears as a second launch or a lost WAIT within one scan. A pending flag that sticks shows up as WAIT on a scan that follows an abort or a completed request.

// File: rtl/jtdp_pkg.sv
package jtdp_pkg;
  localparam int IR_W  = 4;
  localparam int IDC_W = 32;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] INS_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] INS_IDCODE  = 4'b1110;
  localparam logic [IR_W-1:0] INS_DPACC   = 4'b1010;
  localparam logic [IR_W-1:0] INS_APACC   = 4'b1011;
  localparam logic [IR_W-1:0] INS_ABORT   = 4'b1000;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

  localparam logic [2:0] ACK_WAIT = 3'b001;
  localparam logic [2:0] ACK_OK   = 3'b010;

  localparam logic [1:0] DPA_RES   = 2'b00;
  localparam logic [1:0] DPA_CTRL  = 2'b01;
  localparam logic [1:0] DPA_SEL   = 2'b10;
  localparam logic [1:0] DPA_RDBUF = 2'b11;

  typedef enum logic [2:0] {SEL_BYP, SEL_IDC, SEL_DPA, SEL_APA, SEL_ABT} dr_sel_e;

  function automatic dr_sel_e ir_to_sel(logic [IR_W-1:0] code);
    case (code)
      INS_IDCODE: return SEL_IDC;
      INS_DPACC:  return SEL_DPA;
      INS_APACC:  return SEL_APA;
      INS_ABORT:  return SEL_ABT;
      default:    return SEL_BYP;
    endcase
  endfunction

  function automatic int sel_len(dr_sel_e s, int acc_w);
    case (s)
      SEL_BYP: return 1;
      SEL_IDC: return IDC_W;
      default: return acc_w;
    endcase
  endfunction
endpackage

// File: rtl/jtdp_tap.sv
module jtdp_tap
  import jtdp_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SH_DR;
      SH_DR:  state_d = tms_i ? EX1_DR : SH_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PA_DR;
      PA_DR:  state_d = tms_i ? EX2_DR : PA_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SH_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SH_IR;
      SH_IR:  state_d = tms_i ? EX1_IR : SH_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PA_IR;
      PA_IR:  state_d = tms_i ? EX2_IR : PA_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SH_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/jtdp_ir.sv
module jtdp_ir
  import jtdp_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            lsb_o
);
  logic [IR_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= IR_CAPTURE;
      ir_q <= INS_IDCODE;
    end else begin
      case (state_i)
        TLR:    ir_q <= INS_IDCODE;
        CAP_IR: sh_q <= IR_CAPTURE;
        SH_IR:  sh_q <= {tdi_i, sh_q[IR_W-1:1]};
        UPD_IR: ir_q <= sh_q;
        default: ;
      endcase
    end
  end

  assign ir_o  = ir_q;
  assign lsb_o = sh_q[0];
endmodule

// File: rtl/jtdp_dr.sv
module jtdp_dr
  import jtdp_pkg::*;
#(
  parameter int DR_W = 35
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  dr_sel_e         sel_i,
  input  logic            tdi_i,
  input  logic [DR_W-1:0] cap_i,
  output logic [DR_W-1:0] sh_o
);
  logic [DR_W-1:0] sh_q, sh_d;
  int len;

  // tdi enters at the top bit of the selected length; bits above it hold
  always_comb begin
    len  = sel_len(sel_i, DR_W);
    sh_d = sh_q;
    for (int i = 0; i < DR_W-1; i++) begin
      if (i == len-1)     sh_d[i] = tdi_i;
      else if (i < len-1) sh_d[i] = sh_q[i+1];
    end
    if (len == DR_W) sh_d[DR_W-1] = tdi_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                sh_q <= '0;
    else if (state_i == CAP_DR) sh_q <= cap_i;
    else if (state_i == SH_DR)  sh_q <= sh_d;
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/jtdp_access.sv
module jtdp_access
  import jtdp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int DR_W  = DATA_W + 3
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  dr_sel_e           sel_i,
  input  logic [DR_W-1:0]   sh_i,
  output logic [DR_W-1:0]   cap_o,
  output logic              ap_req_o,
  output logic              ap_wr_o,
  output logic [1:0]        ap_addr_o,
  output logic [DATA_W-1:0] ap_wdata_o,
  input  logic              ap_ack_i,
  input  logic [DATA_W-1:0] ap_rdata_i,
  output logic              abort_o
);
  logic [DATA_W-1:0] ctrl_q, select_q, rdbuf_q, wdata_q;
  logic [1:0]        addr_q;
  logic              req_q, wr_q, waited_q, abort_q;

  logic              is_acc, upd_rnw;
  logic [1:0]        upd_addr;
  logic [DATA_W-1:0] upd_data;

  assign is_acc   = (sel_i == SEL_DPA) || (sel_i == SEL_APA);
  assign upd_rnw  = sh_i[0];
  assign upd_addr = sh_i[2:1];
  assign upd_data = sh_i[DR_W-1:3];

  assign cap_o = req_q ? {{DATA_W{1'b0}}, ACK_WAIT} : {rdbuf_q, ACK_OK};

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      select_q <= '0;
      rdbuf_q  <= '0;
      wdata_q  <= '0;
      addr_q   <= '0;
      req_q    <= 1'b0;
      wr_q     <= 1'b0;
      waited_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      abort_q <= 1'b0;
      if (req_q && ap_ack_i) begin
        req_q <= 1'b0;
        if (!wr_q) rdbuf_q <= ap_rdata_i;
      end
      if (state_i == CAP_DR && is_acc) waited_q <= req_q;
      if (state_i == UPD_DR) begin
        if (sel_i == SEL_ABT && upd_data[0]) begin
          abort_q <= 1'b1;
          req_q   <= 1'b0;
        end
        if (!waited_q && sel_i == SEL_DPA) begin
          case (upd_addr)
            DPA_RES:   if (upd_rnw) rdbuf_q <= '0;
            DPA_CTRL:  if (upd_rnw) rdbuf_q <= ctrl_q;   else ctrl_q   <= upd_data;
            DPA_SEL:   if (upd_rnw) rdbuf_q <= select_q; else select_q <= upd_data;
            default: ;
          endcase
        end
        if (!waited_q && sel_i == SEL_APA) begin
          req_q   <= 1'b1;
          wr_q    <= !upd_rnw;
          addr_q  <= upd_addr;
          wdata_q <= upd_data;
        end
      end
    end
  end

  assign ap_req_o   = req_q;
  assign ap_wr_o    = wr_q;
  assign ap_addr_o  = addr_q;
  assign ap_wdata_o = wdata_q;
  assign abort_o    = abort_q;
endmodule

// File: rtl/jtdp_top.sv
module jtdp_top
  import jtdp_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] IDCODE_VAL = 32'h3BA0_0477,
  localparam int         DR_W       = DATA_W + 3
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              ap_req_o,
  output logic              ap_wr_o,
  output logic [1:0]        ap_addr_o,
  output logic [DATA_W-1:0] ap_wdata_o,
  input  logic              ap_ack_i,
  input  logic [DATA_W-1:0] ap_rdata_i,
  output logic              abort_o
);
  tap_state_e      tap_state;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  dr_sel_e         dr_sel;
  logic [DR_W-1:0] dr_sh, dr_cap, acc_cap;
  logic            tdo_q;

  jtdp_tap u_tap (
    .tck_i, .rst_ni, .tms_i,
    .state_o (tap_state)
  );

  jtdp_ir u_ir (
    .tck_i, .rst_ni,
    .state_i (tap_state),
    .tdi_i,
    .ir_o    (ir_q),
    .lsb_o   (ir_lsb)
  );

  assign dr_sel = ir_to_sel(ir_q);

  always_comb begin
    case (dr_sel)
      SEL_IDC:          dr_cap = DR_W'(IDCODE_VAL);
      SEL_DPA, SEL_APA: dr_cap = acc_cap;
      default:          dr_cap = '0;
    endcase
  end

  jtdp_dr #(.DR_W(DR_W)) u_dr (
    .tck_i, .rst_ni,
    .state_i (tap_state),
    .sel_i   (dr_sel),
    .tdi_i,
    .cap_i   (dr_cap),
    .sh_o    (dr_sh)
  );

  jtdp_access #(.DATA_W(DATA_W)) u_acc (
    .tck_i, .rst_ni,
    .state_i    (tap_state),
    .sel_i      (dr_sel),
    .sh_i       (dr_sh),
    .cap_o      (acc_cap),
    .ap_req_o, .ap_wr_o, .ap_addr_o, .ap_wdata_o,
    .ap_ack_i, .ap_rdata_i,
    .abort_o
  );

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else begin
      case (tap_state)
        SH_IR:   tdo_q <= ir_lsb;
        SH_DR:   tdo_q <= dr_sh[0];
        default: tdo_q <= 1'b0;
      endcase
    end
  end

  assign tdo_o = tdo_q;
endmodule

// File: rtl/jtdp_chk.sv
module jtdp_chk
  import jtdp_pkg::*;
#(
  parameter int DR_W = 35
) (
  input logic            tck_i,
  input logic            rst_ni,
  input tap_state_e      state_i,
  input logic [IR_W-1:0] ir_i,
  input logic [DR_W-1:0] dr_i,
  input logic            ap_req_i,
  input logic            ap_ack_i,
  input logic [1:0]      ap_addr_i,
  input logic [DR_W-4:0] ap_wdata_i,
  input logic            abort_i
);
  logic known_ins;
  assign known_ins = (ir_i == INS_IDCODE) || (ir_i == INS_DPACC) ||
                     (ir_i == INS_APACC)  || (ir_i == INS_ABORT);

  // R1
  tlr_ir_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == TLR |=> ir_i == INS_IDCODE);

  // R4
  bypass_cap_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == CAP_DR && !known_ins) |=> dr_i[0] == 1'b0);

  // R11
  ack_code_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == CAP_DR && (ir_i == INS_DPACC || ir_i == INS_APACC))
    |=> (dr_i[2:0] == ACK_WAIT || dr_i[2:0] == ACK_OK));

  // R8
  req_stable_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ap_req_i && !ap_ack_i) |=> (!ap_req_i || ($stable(ap_addr_i) && $stable(ap_wdata_i))));

  // R9
  req_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ap_req_i && !ap_ack_i) |=> (ap_req_i || abort_i));

  // R10
  abort_pulse_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    abort_i |=> !abort_i);
endmodule

bind jtdp_top jtdp_chk #(.DR_W(DR_W)) u_chk (
  .tck_i      (tck_i),
  .rst_ni     (rst_ni),
  .state_i    (tap_state),
  .ir_i       (ir_q),
  .dr_i       (dr_sh),
  .ap_req_i   (ap_req_o),
  .ap_ack_i   (ap_ack_i),
  .ap_addr_i  (ap_addr_o),
  .ap_wdata_i (ap_wdata_o),
  .abort_i    (abort_o)
);

// File: tb/sim_jtdp_top.sv
`timescale 1ns/1ps
module sim_jtdp_top;
  logic        tck_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tms_i = 1'b1;
  logic        tdi_i = 1'b0;
  logic        tdo_o;
  logic        ap_req_o, ap_wr_o, abort_o;
  logic [1:0]  ap_addr_o;
  logic [31:0] ap_wdata_o;
  logic        ap_ack_i = 1'b0;
  logic [31:0] ap_rdata_i = '0;

  int checks = 0;
  int fails  = 0;
  int ap_lat = 2;
  int lat_cnt = 0;
  int launches = 0;
  int aborts = 0;
  logic prev_req = 1'b0;
  logic [31:0] bank [4];
  logic [1:0]  last_addr;
  logic        last_wr;

  always #5 tck_i = ~tck_i;

  jtdp_top u0 (.*);

  // behavioural access-port register bank
  always @(negedge tck_i) begin
    if (ap_req_o && !prev_req) begin
      launches++;
      last_addr = ap_addr_o;
      last_wr   = ap_wr_o;
    end
    prev_req = ap_req_o;
    if (abort_o) aborts++;
    if (ap_req_o && !ap_ack_i) begin
      if (lat_cnt >= ap_lat) begin
        ap_ack_i = 1'b1;
        if (ap_wr_o) bank[ap_addr_o] = ap_wdata_o;
        else         ap_rdata_i = bank[ap_addr_o];
        lat_cnt = 0;
      end else lat_cnt++;
    end else begin
      ap_ack_i = 1'b0;
      if (!ap_req_o) lat_cnt = 0;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic tms, input logic tdi, output logic tdo);
    @(negedge tck_i);
    #1;
    tdo   = tdo_o;
    tms_i = tms;
    tdi_i = tdi;
    @(posedge tck_i);
  endtask

  task automatic idle(input int n);
    logic x;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, x);
  endtask

  task automatic shift_ir(input logic [3:0] code, output logic [3:0] dout);
    logic x;
    step(1, 0, x); step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < 4; i++) step(i == 3, code[i], dout[i]);
    step(1, 0, x); step(0, 0, x);
  endtask

  task automatic scan_dr(input int len, input logic [34:0] din, output logic [34:0] dout);
    logic x;
    dout = '0;
    step(1, 0, x); step(0, 0, x); step(0, 0, x);
    for (int i = 0; i < len; i++) step(i == len-1, din[i], dout[i]);
    step(1, 0, x); step(0, 0, x);
  endtask

  function automatic logic [34:0] acc(input logic [31:0] d, input logic [1:0] a, input logic rnw);
    return {d, a, rnw};
  endfunction

  task automatic t_reset_idcode;
    logic [34:0] o;
    scan_dr(32, '0, o);
    chk(o[31:0], 32'h3BA00477, "R1 idcode after reset");
    chk(o[31:28], 4'h3, "R3 version field");
    chk(o[27:12], 16'hBA00, "R3 part field");
    chk(o[11:1], 11'h23B, "R3 manufacturer field");
    chk(o[0], 1'b1, "R3 bit0");
  endtask

  task automatic t_ir_capture;
    logic [3:0] o;
    logic [34:0] d;
    logic x;
    shift_ir(4'b1111, o);
    chk(o, 4'b0001, "R2 IR capture");
    // TLR via TMS loads IDCODE again
    for (int i = 0; i < 5; i++) step(1, 0, x);
    step(0, 0, x);
    scan_dr(32, '0, d);
    chk(d[31:0], 32'h3BA00477, "R1 idcode after TLR");
  endtask

  task automatic t_bypass;
    logic [3:0] codes [4] = '{4'b1111, 4'b0000, 4'b0101, 4'b1100};
    logic [3:0] o;
    logic [34:0] d;
    logic [7:0] pat = 8'b1011_0101;
    for (int k = 0; k < 4; k++) begin
      shift_ir(codes[k], o);
      scan_dr(8, {27'b0, pat}, d);
      chk(d[7:0], {pat[6:0], 1'b0}, $sformatf("R4 bypass code %b", codes[k]));
    end
  endtask

  task automatic t_dp_regs;
    logic [3:0] o;
    logic [34:0] d;
    shift_ir(4'b1010, o);
    scan_dr(35, acc(32'hA5A5_0F0F, 2'b01, 0), d);
    chk(d[2:0], 3'b010, "R5 ack on DP write");
    scan_dr(35, acc(32'h0000_00F0, 2'b10, 0), d);
    scan_dr(35, acc('0, 2'b01, 1), d);
    scan_dr(35, acc('0, 2'b10, 1), d);
    chk(d[34:3], 32'hA5A5_0F0F, "R5 ctrl read posted");
    chk(d[2:0], 3'b010, "R5 ack ok");
    scan_dr(35, acc('0, 2'b11, 1), d);
    chk(d[34:3], 32'h0000_00F0, "R5 select read posted");
    // R6 reserved address
    scan_dr(35, acc(32'hFFFF_FFFF, 2'b00, 0), d);
    scan_dr(35, acc('0, 2'b00, 1), d);
    scan_dr(35, acc('0, 2'b11, 1), d);
    chk(d[34:3], 32'h0, "R6 reserved reads zero");
    // R7 read buffer
    scan_dr(35, acc('0, 2'b01, 1), d);
    scan_dr(35, acc(32'h1234_5678, 2'b11, 0), d);
    scan_dr(35, acc('0, 2'b11, 1), d);
    chk(d[34:3], 32'hA5A5_0F0F, "R7 rdbuf after write to it");
    scan_dr(35, acc('0, 2'b11, 1), d);
    chk(d[34:3], 32'hA5A5_0F0F, "R7 rdbuf read repeat");
  endtask

  task automatic t_ap;
    logic [3:0] o;
    logic [34:0] d;
    int l0;
    ap_lat = 2;
    shift_ir(4'b1011, o);
    l0 = launches;
    scan_dr(35, acc(32'hCAFE_0001, 2'b01, 0), d);
    idle(6);
    chk(launches - l0, 1, "R8 one launch");
    chk({last_wr, last_addr}, {1'b1, 2'b01}, "R8 write addr");
    chk(bank[1], 32'hCAFE_0001, "R8 write data");
    scan_dr(35, acc('0, 2'b01, 1), d);
    idle(6);
    scan_dr(35, acc('0, 2'b10, 1), d);
    chk(d[34:3], 32'hCAFE_0001, "R8 posted read");
    chk(d[2:0], 3'b010, "R8 ack ok");
    idle(6);
  endtask

  task automatic t_wait;
    logic [3:0] o;
    logic [34:0] d;
    int l0;
    ap_lat = 30;
    l0 = launches;
    scan_dr(35, acc('0, 2'b01, 1), d);
    scan_dr(35, acc(32'hDEAD_BEEF, 2'b01, 0), d);
    chk(d[2:0], 3'b001, "R9 wait ack");
    chk(d[34:3], 32'h0, "R9 wait data zero");
    idle(40);
    chk(launches - l0, 1, "R9 update ignored");
    chk(bank[1], 32'hCAFE_0001, "R9 write not performed");
    scan_dr(35, acc('0, 2'b11, 1), d);
    chk(d[34:3], 32'hCAFE_0001, "R9 earlier read still delivered");
    chk(d[2:0], 3'b010, "R9 ok after completion");
    ap_lat = 2;
    idle(6);
  endtask

  task automatic t_abort;
    logic [3:0] o;
    logic [34:0] d;
    int a0;
    ap_lat = 5000;
    scan_dr(35, acc('0, 2'b00, 1), d);
    idle(2);
    chk(ap_req_o, 1'b1, "R10 request pending before abort");
    a0 = aborts;
    shift_ir(4'b1000, o);
    scan_dr(35, acc(32'h0000_0001, 2'b00, 0), d);
    idle(1);
    chk(aborts - a0, 1, "R10 single abort pulse");
    chk(ap_req_o, 1'b0, "R10 request dropped");
    scan_dr(35, acc(32'hFFFF_FFFE, 2'b11, 1), d);
    idle(1);
    chk(aborts - a0, 1, "R10 no pulse when bit clear");
    ap_lat = 2;
    shift_ir(4'b1011, o);
    scan_dr(35, acc('0, 2'b10, 1), d);
    chk(d[2:0], 3'b010, "R11 ok after abort");
    idle(6);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) bank[i] = '0;
    #22 rst_ni = 1'b1;
    #1 chk(tdo_o, 1'b0, "R2 tdo reset");
    idle(1);
    t_reset_idcode();
    t_ir_capture();
    t_bypass();
    t_dp_regs();
    t_ap();
    t_wait();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck_i);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule